// File: doc/BRIEF.md
# Multiplexed-Address Asynchronous DRAM Controller

This block sits between a simple processor bus and a bank of eight 64K x 1 asynchronous DRAM devices that share their address and strobe lines. It accepts one 16-bit address per request, with a read/write flag and a write byte. The address goes out on eight shared pins in two steps: first the upper byte as the row, then the lower byte as the column. The block generates active-low row strobe, column strobe, write enable and output enable. Every interval between strobe edges is a parameter counted in system clock cycles.

The processor raises `reqValid` and holds it until it sees the one-cycle `reqAck` pulse. From acceptance onward `waitOut` stalls the processor. `waitOut` falls in the first cycle in which `rdData` holds the captured read byte, or once the write is complete. A free-running timer also requests refresh. Each refresh is a cycle that pulses only the row strobe, and the refresh row counter advances by one each time. A request that arrives during a refresh waits until the refresh has finished.

Top module: `dram_addr_mux_ctrl`

## Requirements
- R1: For the row strobe's falling edge, `memAddr` carries the request address bits [15:8]. For the column strobe's falling edge, it carries bits [7:0].
- R2: The column strobe falls only while the row strobe is low. At the end of a cycle the column strobe is high for at least one cycle before the row strobe rises.
- R3: The row address stays on `memAddr` with the row strobe high for T_ASR cycles. The column strobe then falls exactly T_RCD+1 cycles after the row strobe.
- R4: In a read, write enable stays high. Output enable is low only while the column strobe is low. The byte on `memDqIn` is captured into `rdData` after the column strobe has been low for T_CAC cycles.
- R5: In a write, write enable is low before the column strobe falls, and `memDqOut` is driven with the write byte (`memDqOe` high). Output enable stays high.
- R6: Whenever both the row strobe and the column strobe are high, `memDqOe` is low.
- R7: Between two row strobe low periods, the row strobe stays high for at least T_RP cycles.
- R8: `waitOut` rises with acceptance and stays high for exactly T_ASR+T_RCD+1+T_CAC cycles. In the first cycle in which it is low, `rdData` holds the read byte.
- R9: Each accepted request produces exactly one single-cycle `reqAck` pulse.
- R10: Every REF_PERIOD cycles a refresh cycle runs in which only the row strobe pulses. Refresh rows start at 0 and go up by one, wrapping modulo 256.
- R11: A request raised while a refresh is in progress is accepted only after that refresh's row strobe has returned high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Access request, held until acknowledged |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Byte address; [15:8] row, [7:0] column |
| reqWData | input | 8 | Write byte |
| reqAck | output | 1 | One-cycle acceptance pulse |
| waitOut | output | 1 | Processor stall from acceptance to completion |
| rdData | output | 8 | Registered read byte |
| memAddr | output | 8 | Shared multiplexed address pins |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| oeN | output | 1 | Output enable, active low |
| memDqOut | output | 8 | Data toward the devices |
| memDqOe | output | 1 | Drive enable for memDqOut; low means released |
| memDqIn | input | 8 | Data from the devices |

## Verification
The bench models the device array, latching row and column on the strobe falling edges. It sweeps a full column line and a full diagonal of rows, writing every address and then reading every one back, so a swapped or shifted address half lands bytes in the wrong cell and shows as data miscompares. It overwrites one cell next to a neighbour, so a write enable asserted at the wrong time corrupts either cell. It measures the strobe spacing and the stall length cycle by cycle, so an off-by-one counter or a strobe released in the wrong order is reported even when the data still matches. It lets the refresh timer wrap the row counter and starts a request in the middle of a refresh, so a controller that preempts refresh or skips rows is caught.

// File: rtl/dram_mux_pkg.sv
`timescale 1ns/1ps
package dram_mux_pkg;

  typedef enum logic [1:0] {
    SEL_ROW,
    SEL_COL,
    SEL_REF
  } addrSel_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic     latchReq;
    addrSel_e addrSel;
    logic     capture;
    logic     bumpRef;
  } dpStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROWSET,
    ST_RASLO,
    ST_COLSET,
    ST_CASLO,
    ST_CASHI,
    ST_PRECH,
    ST_REFROW,
    ST_REFRAS
  } seqState_e;

endpackage

// File: rtl/dram_refresh_timer.sv
`timescale 1ns/1ps
module dram_refresh_timer #(
  parameter int REF_PERIOD = 3900
) (
  input  logic clk,
  input  logic rstN,
  input  logic take,
  output logic pending
);
  localparam int TW = $clog2(REF_PERIOD + 1);

  logic [TW-1:0] tickCnt;
  logic          tick;

  assign tick = (tickCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= TW'(REF_PERIOD - 1);
      pending <= 1'b0;
    end else begin
      tickCnt <= tick ? TW'(REF_PERIOD - 1) : tickCnt - 1'b1;
      if (tick)
        pending <= 1'b1;
      else if (take)
        pending <= 1'b0;
    end
  end
endmodule

// File: rtl/dram_mux_datapath.sv
`timescale 1ns/1ps
module dram_mux_datapath
  import dram_mux_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           ctl,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWData,
  input  logic                reqWrite,
  input  logic [DATA_W-1:0]   memDqIn,
  output logic [ADDR_W/2-1:0] memAddr,
  output logic [DATA_W-1:0]   memDqOut,
  output logic [DATA_W-1:0]   rdData,
  output logic                isWrite
);
  localparam int HALF_W = ADDR_W / 2;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [HALF_W-1:0] refRow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '0;
      isWrite <= 1'b0;
    end else if (ctl.latchReq) begin
      addrQ   <= reqAddr;
      dataQ   <= reqWData;
      isWrite <= reqWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      refRow <= '0;
    else if (ctl.bumpRef)
      refRow <= refRow + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdData <= '0;
    else if (ctl.capture)
      rdData <= memDqIn;
  end

  always_comb begin
    unique case (ctl.addrSel)
      SEL_COL: memAddr = addrQ[HALF_W-1:0];
      SEL_REF: memAddr = refRow;
      default: memAddr = addrQ[ADDR_W-1:HALF_W];
    endcase
  end

  assign memDqOut = dataQ;
endmodule

// File: rtl/dram_mux_sequencer.sv
`timescale 1ns/1ps
module dram_mux_sequencer
  import dram_mux_pkg::*;
#(
  parameter int T_ASR = 1,
  parameter int T_RCD = 5,
  parameter int T_CAC = 8,
  parameter int T_RP  = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      isWrite,
  input  logic      refPending,
  output logic      refTake,
  output dpStrobe_t ctl,
  output logic      rasN,
  output logic      casN,
  output logic      weN,
  output logic      oeN,
  output logic      memDqOe,
  output logic      reqAck,
  output logic      waitOut
);
  localparam int REF_LOW = T_RCD + T_CAC + 1;
  localparam int MAX_A   = (T_ASR > T_RP) ? T_ASR : T_RP;
  localparam int MAX_LEN = (MAX_A > REF_LOW) ? MAX_A : REF_LOW;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  seqState_e        state, nextState;
  logic [CNT_W-1:0] cnt, loadVal;
  logic             lastCycle, accept, finish;

  assign lastCycle = (cnt == '0);

  always_comb begin
    nextState = state;
    loadVal   = '0;
    accept    = 1'b0;
    refTake   = 1'b0;
    finish    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (refPending) begin
          nextState = ST_REFROW;
          loadVal   = CNT_W'(T_ASR - 1);
          refTake   = 1'b1;
        end else if (reqValid) begin
          nextState = ST_ROWSET;
          loadVal   = CNT_W'(T_ASR - 1);
          accept    = 1'b1;
        end
      end
      ST_ROWSET: if (lastCycle) begin
        nextState = ST_RASLO;
        loadVal   = CNT_W'(T_RCD - 1);
      end
      ST_RASLO: if (lastCycle) nextState = ST_COLSET;
      ST_COLSET: begin
        nextState = ST_CASLO;
        loadVal   = CNT_W'(T_CAC - 1);
      end
      ST_CASLO: if (lastCycle) begin
        nextState = ST_CASHI;
        finish    = 1'b1;
      end
      ST_CASHI: begin
        nextState = ST_PRECH;
        loadVal   = CNT_W'(T_RP - 1);
      end
      ST_PRECH: if (lastCycle) nextState = ST_IDLE;
      ST_REFROW: if (lastCycle) begin
        nextState = ST_REFRAS;
        loadVal   = CNT_W'(REF_LOW - 1);
      end
      ST_REFRAS: if (lastCycle) begin
        nextState = ST_PRECH;
        loadVal   = CNT_W'(T_RP - 1);
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      reqAck  <= 1'b0;
      waitOut <= 1'b0;
    end else begin
      state  <= nextState;
      reqAck <= accept;
      if (nextState != state)
        cnt <= loadVal;
      else if (!lastCycle)
        cnt <= cnt - 1'b1;
      if (accept)
        waitOut <= 1'b1;
      else if (finish)
        waitOut <= 1'b0;
    end
  end

  // strobe decode from the registered state
  logic rasLow, colPhase;
  assign rasLow   = (state == ST_RASLO) || (state == ST_COLSET) || (state == ST_CASLO)
                 || (state == ST_CASHI) || (state == ST_REFRAS);
  assign colPhase = (state == ST_COLSET) || (state == ST_CASLO);

  assign rasN    = !rasLow;
  assign casN    = (state != ST_CASLO);
  assign weN     = !(isWrite && colPhase);
  assign oeN     = !(!isWrite && state == ST_CASLO);
  assign memDqOe = isWrite && (colPhase || state == ST_CASHI);

  always_comb begin
    ctl.latchReq = accept;
    ctl.capture  = finish && !isWrite;
    ctl.bumpRef  = (state == ST_REFRAS) && lastCycle;
    if (state == ST_REFROW || state == ST_REFRAS)
      ctl.addrSel = SEL_REF;
    else if (colPhase || state == ST_CASHI)
      ctl.addrSel = SEL_COL;
    else
      ctl.addrSel = SEL_ROW;
  end
endmodule

// File: rtl/dram_addr_mux_ctrl.sv
`timescale 1ns/1ps
module dram_addr_mux_ctrl
  import dram_mux_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int T_ASR      = 1,
  parameter int T_RCD      = 5,
  parameter int T_CAC      = 8,
  parameter int T_RP       = 6,
  parameter int REF_PERIOD = 3900
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWData,
  output logic                reqAck,
  output logic                waitOut,
  output logic [DATA_W-1:0]   rdData,
  output logic [ADDR_W/2-1:0] memAddr,
  output logic                rasN,
  output logic                casN,
  output logic                weN,
  output logic                oeN,
  output logic [DATA_W-1:0]   memDqOut,
  output logic                memDqOe,
  input  logic [DATA_W-1:0]   memDqIn
);
  dpStrobe_t ctl;
  logic      isWrite, refPending, refTake;

  dram_refresh_timer #(.REF_PERIOD(REF_PERIOD)) refresh_i (
    .clk(clk), .rstN(rstN), .take(refTake), .pending(refPending)
  );

  dram_mux_sequencer #(
    .T_ASR(T_ASR), .T_RCD(T_RCD), .T_CAC(T_CAC), .T_RP(T_RP)
  ) seq_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .isWrite(isWrite),
    .refPending(refPending), .refTake(refTake), .ctl(ctl),
    .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN), .memDqOe(memDqOe),
    .reqAck(reqAck), .waitOut(waitOut)
  );

  dram_mux_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqWData(reqWData),
    .reqWrite(reqWrite), .memDqIn(memDqIn), .memAddr(memAddr),
    .memDqOut(memDqOut), .rdData(rdData), .isWrite(isWrite)
  );
endmodule

// File: rtl/dram_addr_mux_ctrl_checker.sv
`timescale 1ns/1ps
module dram_addr_mux_ctrl_checker #(
  parameter int T_RCD = 5,
  parameter int T_RP  = 6
) (
  input logic clk,
  input logic rstN,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic oeN,
  input logic memDqOe,
  input logic reqAck,
  input logic waitOut
);
  localparam int LOW_LIM = T_RCD + 1;
  localparam int LW      = $clog2(LOW_LIM + 1);
  localparam int HW      = $clog2(T_RP + 1);

  logic [LW-1:0] rasLowCnt;
  logic [HW-1:0] rasHighCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasLowCnt  <= '0;
      rasHighCnt <= HW'(T_RP);
    end else begin
      if (rasN)
        rasLowCnt <= '0;
      else if (rasLowCnt != LW'(LOW_LIM))
        rasLowCnt <= rasLowCnt + 1'b1;
      if (!rasN)
        rasHighCnt <= '0;
      else if (rasHighCnt != HW'(T_RP))
        rasHighCnt <= rasHighCnt + 1'b1;
    end
  end

  assert_cas_inside_ras_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> !rasN);
  assert_cas_rises_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (casN && $past(casN)));
  assert_ras_to_cas_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> (int'(rasLowCnt) >= LOW_LIM));
  assert_oe_read_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> (!casN && weN));
  assert_we_with_data_R5: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> (!rasN && oeN && memDqOe));
  assert_deselect_float_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rasN && casN) |-> !memDqOe);
  assert_precharge_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (int'(rasHighCnt) >= T_RP));
  assert_wait_on_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> waitOut);
  assert_single_ack_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);
endmodule

bind dram_addr_mux_ctrl dram_addr_mux_ctrl_checker #(.T_RCD(T_RCD), .T_RP(T_RP)) chk_i (
  .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
  .memDqOe(memDqOe), .reqAck(reqAck), .waitOut(waitOut)
);

// File: tb/dram_addr_mux_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_addr_mux_ctrl_tb_top;
  localparam int TA = 1, TR = 2, TC = 3, TP = 2, RP = 40;
  localparam int WAIT_LEN = TA + TR + 1 + TC;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWData = '0;
  logic        reqAck, waitOut, rasN, casN, weN, oeN, memDqOe;
  logic [7:0]  rdData, memAddr, memDqOut, memDqIn;

  always #2 clk = ~clk;

  dram_addr_mux_ctrl #(
    .T_ASR(TA), .T_RCD(TR), .T_CAC(TC), .T_RP(TP), .REF_PERIOD(RP)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWData(reqWData), .reqAck(reqAck), .waitOut(waitOut),
    .rdData(rdData), .memAddr(memAddr), .rasN(rasN), .casN(casN), .weN(weN),
    .oeN(oeN), .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int nVec = 0, nFail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // device array model
  logic [7:0]  cellMem [0:65535];
  logic [7:0]  rowL = '0, colL = '0, modelOut = '0, expRef = '0;
  logic        prevRas = 1'b1, prevCas = 1'b1, sawCas = 1'b0;
  int          cyc = 0, rasFallCyc = 0, rasRiseCyc = -100, casRiseCyc = -100;
  int          refCount = 0;
  logic [15:0] curAddr = '0;
  logic [7:0]  curData = '0;
  logic        curWrite = 1'b0;

  assign memDqIn = (!casN && !oeN) ? modelOut : 8'h00;

  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (rasN && casN)
        check(!memDqOe, "R6", int'(memDqOe), 0);
      if (prevRas && !rasN) begin
        rowL = memAddr;
        sawCas = 1'b0;
        check(cyc - rasRiseCyc >= TP, "R7", cyc - rasRiseCyc, TP);
        rasFallCyc = cyc;
      end
      if (prevCas && !casN) begin
        colL = memAddr;
        sawCas = 1'b1;
        check(!rasN, "R2", int'(rasN), 0);
        check(cyc - rasFallCyc == TR + 1, "R3", cyc - rasFallCyc, TR + 1);
        check({rowL, colL} == curAddr, "R1", int'({rowL, colL}), int'(curAddr));
        if (curWrite) begin
          check(!weN && oeN && memDqOe, "R5", int'({weN, oeN, memDqOe}), 3'b011);
          check(memDqOut == curData, "R5", int'(memDqOut), int'(curData));
          cellMem[{rowL, colL}] = memDqOut;
        end else begin
          check(weN, "R4", int'(weN), 1);
          modelOut = cellMem[{rowL, colL}];
        end
      end
      if (!prevCas && casN)
        casRiseCyc = cyc;
      if (!prevRas && rasN) begin
        check(casN && (cyc - casRiseCyc >= 1), "R2", cyc - casRiseCyc, 1);
        if (!sawCas) begin
          check(rowL == expRef, "R10", int'(rowL), int'(expRef));
          expRef = expRef + 8'd1;
          refCount++;
        end
        rasRiseCyc = cyc;
      end
      prevRas = rasN;
      prevCas = casN;
    end
  end

  function automatic logic [7:0] dataFn(input logic [15:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd7;
    return m ^ a[15:8] ^ 8'h5A;
  endfunction

  int lastAckRef = 0;

  task automatic access(input logic w, input logic [15:0] a, input logic [7:0] d,
                        output logic [7:0] q);
    int acks, wcnt, guard;
    curAddr = a; curWrite = w; curData = d;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWData = d;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!reqAck && guard < 1000);
    lastAckRef = refCount;
    reqValid = 1'b0;
    acks = 1;
    wcnt = waitOut ? 1 : 0;
    check(waitOut, "R8", int'(waitOut), 1);
    while (guard < 2000) begin
      @(negedge clk);
      guard++;
      if (reqAck) acks++;
      if (waitOut) wcnt++;
      else break;
    end
    check(wcnt == WAIT_LEN, "R8", wcnt, WAIT_LEN);
    check(acks == 1, "R9", acks, 1);
    q = rdData;
  endtask

  logic [15:0] addrs [0:511];

  initial begin
    logic [7:0] q;
    int rc0;
    repeat (5) @(negedge clk);
    check(rasN && casN && weN && oeN, "R6", int'({rasN, casN, weN, oeN}), 4'hF);
    check(!memDqOe && !waitOut && !reqAck, "R8", int'({memDqOe, waitOut, reqAck}), 0);
    rstN = 1'b1;

    for (int i = 0; i < 512; i++)
      addrs[i] = (i < 256) ? {8'h3C, 8'(i)} : {8'(i), ~8'(i)};

    // R5: full sweep of writes, R4: full readback
    for (int i = 0; i < 512; i++) access(1'b1, addrs[i], dataFn(addrs[i]), q);
    for (int i = 0; i < 512; i++) begin
      access(1'b0, addrs[i], 8'h00, q);
      check(q == dataFn(addrs[i]), "R4", int'(q), int'(dataFn(addrs[i])));
    end

    // R5: overwrite one cell, neighbour untouched
    access(1'b1, 16'h1235, 8'h0F, q);
    access(1'b1, 16'h1234, 8'hAA, q);
    access(1'b1, 16'h1234, 8'h55, q);
    access(1'b0, 16'h1234, 8'h00, q);
    check(q == 8'h55, "R5", int'(q), 8'h55);
    access(1'b0, 16'h1235, 8'h00, q);
    check(q == 8'h0F, "R5", int'(q), 8'h0F);

    // R10: idle refresh rate and row wrap
    rc0 = refCount;
    repeat (256 * RP) @(negedge clk);
    check(refCount - rc0 >= 255 && refCount - rc0 <= 257, "R10", refCount - rc0, 256);
    check(refCount > 256, "R10", refCount, 257);

    // R11: request raised during a refresh waits for it
    while (!(!rasN && casN)) @(negedge clk);
    rc0 = refCount;
    curAddr = 16'h3C05; curWrite = 1'b0;
    access(1'b0, 16'h3C05, 8'h00, q);
    check(lastAckRef == rc0 + 1, "R11", lastAckRef, rc0 + 1);
    check(q == dataFn(16'h3C05), "R11", int'(q), int'(dataFn(16'h3C05)));

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      nVec++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end
endmodule